// File: doc/BRIEF.md
# CAN Acceptance Mask Filter

This block decides, for each of a set of message slots, whether the identifier of a received CAN frame is accepted. Each slot holds an identifier, a flag that marks it as an extended-format slot, and a flag that marks it valid. The received identifier is compared with the slot's identifier bit by bit. A global mask selects which bits take part in the compare. There are two global masks. One applies to standard 11-bit slots and one applies to extended 29-bit slots. The slot's format flag picks which one is used. A mask bit of 1 forces that identifier bit to be compared. A mask bit of 0 makes it don't-care.

Software loads the two masks through a byte-wide write port. The per-slot match outputs are combinational. They are a function of the current identifier inputs and the registered masks. A downstream store can therefore act on them in the same cycle in which the received identifier is presented. Frame reception, the bit-level protocol, and the choice among several matching slots are left to neighbouring logic.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, both masks are all ones, so every used identifier bit must be equal for a slot to match.
- R2: A write with `cfg_we` high stores `cfg_wdata` into one mask byte at the next rising clock edge. The byte map is as follows. Address 0 holds standard mask bits 10:3 (data bits 7:0). Address 1 holds standard mask bits 2:0 (data bits 7:5). Addresses 2, 3 and 4 hold extended mask bits 28:21, 20:13 and 12:5. Address 5 holds extended mask bits 4:0 (data bits 7:3). Data bits that fall below the identifier width are dropped.
- R3: A valid standard slot (`slot_ext`=0) matches a standard frame (`rx_ext`=0) when `rx_id[10:0]` equals the top 11 bits of the slot identifier (bits 28:18) in every position where the standard mask is 1.
- R4: A valid extended slot (`slot_ext`=1) matches an extended frame (`rx_ext`=1) when `rx_id[28:0]` equals the slot identifier in every position where the extended mask is 1.
- R5: Identifier bits whose mask bit is 0 do not affect the match. With an all-zero mask, any identifier of the right format matches.
- R6: A frame whose format flag differs from the slot's extended flag never matches that slot.
- R7: A slot whose valid flag is 0 never matches.
- R8: For a standard slot, slot identifier bits 17:0 and received identifier bits 28:11 have no effect on the match.
- R9: Writes to addresses 6 and 7 leave both masks unchanged.
- R10: Each slot's match output depends only on that slot's own inputs, the received identifier, and the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mask byte write strobe |
| cfg_addr | input | 3 | Mask byte address (0-5 used) |
| cfg_wdata | input | 8 | Mask byte write data |
| rx_id | input | 29 | Received identifier; standard frames use bits 10:0 |
| rx_ext | input | 1 | Received frame is extended format |
| slot_id | input | NUM_SLOTS*29 | Per-slot identifier, slot k at bits 29k+28:29k |
| slot_ext | input | NUM_SLOTS | Per-slot extended-format flag |
| slot_valid | input | NUM_SLOTS | Per-slot valid flag |
| slot_hit | output | NUM_SLOTS | Per-slot acceptance result |

## Verification
Several rules are checked on every cycle. An invalid slot never hits. A format mismatch never hits. An exact identifier match in the right format always hits. An all-zero mask always hits. Writes to an addressed mask byte land on the next edge. Writes to the unused addresses change nothing. Two things can only be shown by the bench's scenarios, because they need a known mask value and a chosen stimulus: that a single differing bit is rejected when its mask bit is 1 and ignored when it is 0, and that the unused identifier bits of standard slots have no effect.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int BYTE_W     = 8;
    localparam int STD_ID_W   = 11;
    localparam int EXT_ID_W   = 29;
    localparam int STD_BYTES  = (STD_ID_W + BYTE_W - 1) / BYTE_W;
    localparam int EXT_BYTES  = (EXT_ID_W + BYTE_W - 1) / BYTE_W;
    localparam int STD_PAD    = STD_BYTES * BYTE_W - STD_ID_W;
    localparam int EXT_PAD    = EXT_BYTES * BYTE_W - EXT_ID_W;
    localparam int CFG_ADDR_W = 3;

    typedef struct packed {
        logic [STD_ID_W-1:0] std_mask;
        logic [EXT_ID_W-1:0] ext_mask;
    } mask_state_t;
endpackage

// File: rtl/can_mask_regs.sv
module can_mask_regs
    import can_filt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0]     cfg_wdata,
    output logic [STD_ID_W-1:0]   std_mask_q,
    output logic [EXT_ID_W-1:0]   ext_mask_q
);
    mask_state_t st_d, st_q;

    // Byte 0 of each mask is its most significant byte; bits below the
    // identifier width are not stored.
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < STD_ID_W; i++) begin
                if (int'(cfg_addr) == STD_BYTES - 1 - (i + STD_PAD) / BYTE_W)
                    st_d.std_mask[i] = cfg_wdata[3'((i + STD_PAD) % BYTE_W)];
            end
            for (int i = 0; i < EXT_ID_W; i++) begin
                if (int'(cfg_addr) == STD_BYTES + EXT_BYTES - 1 - (i + EXT_PAD) / BYTE_W)
                    st_d.ext_mask[i] = cfg_wdata[3'((i + EXT_PAD) % BYTE_W)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign std_mask_q = st_q.std_mask;
    assign ext_mask_q = st_q.ext_mask;
endmodule

// File: rtl/can_slot_match.sv
module can_slot_match
    import can_filt_pkg::*;
(
    input  logic [EXT_ID_W-1:0] rx_id,
    input  logic                rx_ext,
    input  logic [EXT_ID_W-1:0] slot_id,
    input  logic                slot_ext,
    input  logic                slot_valid,
    input  logic [STD_ID_W-1:0] std_mask,
    input  logic [EXT_ID_W-1:0] ext_mask,
    output logic                hit
);
    logic [STD_ID_W-1:0] std_diff;
    logic [EXT_ID_W-1:0] ext_diff;
    logic                fmt_ok;

    always_comb begin
        // Standard identifiers sit left-aligned in the slot field.
        std_diff = (slot_id[EXT_ID_W-1 -: STD_ID_W] ^ rx_id[STD_ID_W-1:0]) & std_mask;
        ext_diff = (slot_id ^ rx_id) & ext_mask;
        fmt_ok   = (slot_ext == rx_ext);
        hit      = slot_valid && fmt_ok &&
                   (slot_ext ? (ext_diff == '0) : (std_diff == '0));
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_ADDR_W-1:0]         cfg_addr,
    input  logic [BYTE_W-1:0]             cfg_wdata,
    input  logic [EXT_ID_W-1:0]           rx_id,
    input  logic                          rx_ext,
    input  logic [NUM_SLOTS*EXT_ID_W-1:0] slot_id,
    input  logic [NUM_SLOTS-1:0]          slot_ext,
    input  logic [NUM_SLOTS-1:0]          slot_valid,
    output logic [NUM_SLOTS-1:0]          slot_hit
);
    logic [STD_ID_W-1:0] std_mask_q;
    logic [EXT_ID_W-1:0] ext_mask_q;

    can_mask_regs u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .std_mask_q (std_mask_q),
        .ext_mask_q (ext_mask_q)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        can_slot_match u_cmp (
            .rx_id      (rx_id),
            .rx_ext     (rx_ext),
            .slot_id    (slot_id[s*EXT_ID_W +: EXT_ID_W]),
            .slot_ext   (slot_ext[s]),
            .slot_valid (slot_valid[s]),
            .std_mask   (std_mask_q),
            .ext_mask   (ext_mask_q),
            .hit        (slot_hit[s])
        );
    end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
    import can_filt_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_we,
    input logic [CFG_ADDR_W-1:0]         cfg_addr,
    input logic [BYTE_W-1:0]             cfg_wdata,
    input logic [EXT_ID_W-1:0]           rx_id,
    input logic                          rx_ext,
    input logic [NUM_SLOTS*EXT_ID_W-1:0] slot_id,
    input logic [NUM_SLOTS-1:0]          slot_ext,
    input logic [NUM_SLOTS-1:0]          slot_valid,
    input logic [NUM_SLOTS-1:0]          slot_hit,
    input logic [STD_ID_W-1:0]           std_mask_q,
    input logic [EXT_ID_W-1:0]           ext_mask_q
);
    AST_RESET_ALL_ONES: assert property (@(posedge clk)
        $rose(rst_n) |-> (&std_mask_q) && (&ext_mask_q)); // R1

    AST_STD_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == 3'd0 |=> std_mask_q[10:3] == $past(cfg_wdata)); // R2

    AST_EXT_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == 3'd2 |=> ext_mask_q[28:21] == $past(cfg_wdata)); // R2

    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr[2:1] == 2'b11 |=> $stable(std_mask_q) && $stable(ext_mask_q)); // R9

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        logic [EXT_ID_W-1:0] sid;
        assign sid = slot_id[s*EXT_ID_W +: EXT_ID_W];

        AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[s] |-> !slot_hit[s]); // R7

        AST_FORMAT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
            slot_ext[s] != rx_ext |-> !slot_hit[s]); // R6

        AST_STD_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] && !slot_ext[s] && !rx_ext &&
            sid[28:18] == rx_id[10:0] |-> slot_hit[s]); // R3

        AST_EXT_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] && slot_ext[s] && rx_ext && sid == rx_id |-> slot_hit[s]); // R4

        AST_ZERO_MASK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] && slot_ext[s] == rx_ext &&
            (rx_ext ? ext_mask_q == '0 : std_mask_q == '0) |-> slot_hit[s]); // R5
    end
endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .rx_id      (rx_id),
    .rx_ext     (rx_ext),
    .slot_id    (slot_id),
    .slot_ext   (slot_ext),
    .slot_valid (slot_valid),
    .slot_hit   (slot_hit),
    .std_mask_q (std_mask_q),
    .ext_mask_q (ext_mask_q)
);

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
    localparam int NS = 4;
    localparam int IW = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [IW-1:0] rx_id = '0;
    logic          rx_ext = 1'b0;
    logic [NS*IW-1:0] slot_id = '0;
    logic [NS-1:0] slot_ext = '0;
    logic [NS-1:0] slot_valid = '0;
    logic [NS-1:0] slot_hit;

    int total = 0;
    int bad = 0;
    logic [15:0] sh_std = 16'hFFFF;
    logic [31:0] sh_ext = 32'hFFFF_FFFF;

    always #5 clk = ~clk;

    can_accept_filter #(.NUM_SLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_id(rx_id), .rx_ext(rx_ext), .slot_id(slot_id),
        .slot_ext(slot_ext), .slot_valid(slot_valid), .slot_hit(slot_hit)
    );

    function automatic logic [NS-1:0] model();
        logic [NS-1:0] r;
        for (int s = 0; s < NS; s++) begin
            logic [IW-1:0] sid = slot_id[s*IW +: IW];
            if (!slot_valid[s] || slot_ext[s] != rx_ext) r[s] = 1'b0;
            else if (rx_ext) r[s] = (((sid ^ rx_id) & sh_ext[31:3]) == '0);
            else r[s] = (((sid[28:18] ^ rx_id[10:0]) & sh_std[15:5]) == '0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [NS-1:0] exp);
        total++;
        if (slot_hit !== exp) begin
            bad++;
            $display("FAIL %s: slot_hit=%b expected=%b", req, slot_hit, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 3'd2) sh_std[8*(1-int'(a)) +: 8] = d;
        else if (a < 3'd6) sh_ext[8*(5-int'(a)) +: 8] = d;
    endtask

    task automatic set_slot(input int s, input logic [IW-1:0] id, input logic ext, input logic v);
        slot_id[s*IW +: IW] = id; slot_ext[s] = ext; slot_valid[s] = v;
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin : watchdog
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: full compare after reset
        set_slot(0, {11'h5A3, 18'h0}, 1'b0, 1'b1);
        set_slot(1, 29'h0ABC_DEF1, 1'b1, 1'b1);
        rx_ext = 1'b0; rx_id = 29'h5A3; settle();
        check("R1 std exact", 4'b0001);
        rx_id = 29'h5A2; settle();
        check("R1 std one bit off", 4'b0000);
        rx_ext = 1'b1; rx_id = 29'h0ABC_DEF0; settle();
        check("R1 ext one bit off", 4'b0000);
        // R4 exact extended
        rx_id = 29'h0ABC_DEF1; settle();
        check("R4 ext exact", 4'b0010);
        // R6 format mismatch: std frame carrying slot1's id bits
        rx_ext = 1'b0; rx_id = 29'h0ABC_DEF1; slot_id[28:0] = {rx_id[10:0], 18'h0}; settle();
        check("R6 ext slot vs std frame", 4'b0001);
        rx_ext = 1'b1; rx_id = {11'h5A3, 18'h0}; settle();
        check("R6 std slot vs ext frame", 4'b0000);
        // R7 invalid slot
        rx_ext = 1'b1; rx_id = 29'h0ABC_DEF1; slot_valid[1] = 1'b0; settle();
        check("R7 invalid ext slot", 4'b0000);
        slot_valid[1] = 1'b1;
        // R8 unused std bits
        set_slot(0, {11'h5A3, 18'h3_FFFF}, 1'b0, 1'b1);
        rx_ext = 1'b0; rx_id = {18'h2_AAAA, 11'h5A3}; settle();
        check("R8 std low bits ignored", 4'b0001);
        // R2 + R5: std mask low byte 0 clears compare on bits 2:0
        wr(3'd1, 8'h00);
        rx_id = 29'h5A3 ^ 29'h007; settle();
        check("R2 R5 std bits 2:0 dont care", 4'b0001);
        rx_id = 29'h5A3 ^ 29'h008; settle();
        check("R2 std bit 3 still compared", 4'b0000);
        // R2: ext mask addr 5 drops bits 4:0
        wr(3'd5, 8'h07);
        rx_ext = 1'b1; rx_id = 29'h0ABC_DEF1 ^ 29'h01F; settle();
        check("R2 ext bits 4:0 dont care", 4'b0010);
        rx_id = 29'h0ABC_DEF1 ^ 29'h020; settle();
        check("R2 ext bit 5 compared", 4'b0000);
        // R9 writes to 6 and 7 ignored
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 8'h00;
        @(negedge clk); cfg_addr = 3'd7;
        @(negedge clk); cfg_we = 1'b0; settle();
        check("R9 ext bit 5 still compared", 4'b0000);
        rx_ext = 1'b0; rx_id = 29'h5A3 ^ 29'h400; settle();
        check("R9 std bit 10 still compared", 4'b0000);
        // R5 all-zero masks
        wr(3'd0, 8'h00);
        for (int a = 2; a < 6; a++) wr(3'(a), 8'h00);
        rx_id = 29'h1FFF_FFFF; settle();
        check("R5 zero std mask", 4'b0001);
        rx_ext = 1'b1; settle();
        check("R5 zero ext mask", 4'b0010);

        // R10 random: every slot against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 7) == 0)
                wr(3'($urandom_range(0, 7)), ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom));
            @(negedge clk);
            for (int s = 0; s < NS; s++)
                set_slot(s, IW'($urandom), 1'($urandom), ($urandom_range(0, 5) != 0));
            rx_ext = 1'($urandom);
            begin
                int pick = $urandom_range(0, NS - 1);
                logic [IW-1:0] base = slot_id[pick*IW +: IW];
                logic [IW-1:0] flip = ($urandom_range(0, 2) == 0) ? (IW'(1) << $urandom_range(0, IW - 1)) : '0;
                rx_id = slot_ext[pick] ? (base ^ flip) : ({18'($urandom), base[28:18]} ^ flip);
            end
            settle();
            check("R3 R4 R10 random", model());
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule